// File: doc/BRIEF.md
# Unrolled Sine/Cosine Rotator with Constant-Select Front End

This block turns a signed fixed-point angle in radians into its cosine and sine by running a fixed number of coordinate rotations that each use only shifts and additions. The first three rotations need no arithmetic. The start vector is a constant: the reciprocal of the total rotation gain sits on the x axis. For that reason every vector reachable after three rotations is a constant multiple of that start value. The first rotation is therefore never built. Only its direction is read from the angle sign, and the angle residue is updated. The second and third rotations become multiplexers over precomputed constant pairs, and the sign bits of the residual angle drive their selects. The rotations after that are ordinary shift-and-add stages. Their shift distances and arctangent constants are wired in.

A parameter picks between a fully combinational datapath and a two-level pipelined one. The pipelined form holds a register after the constant-select front end and another at the output. It accepts one angle per clock and returns each result two clocks later, with the result strobe delayed to match. Angles, cosines and sines share one signed 16-bit format with 13 fractional bits. The gain correction is folded into the start constant, so no multiplier is needed.

Top module: `cordic_sincos`

## Requirements
- R1: While reset is high at a clock edge, the pipelined unit clears its result strobe and both result words to zero on that edge.
- R2: Angles and results are signed 16-bit two's complement with 13 fractional bits (8192 = 1.0). For any angle within ±1.74 rad, `res_cos` lies within 120 LSB of the true cosine.
- R3: For any angle within ±1.74 rad, `res_sin` lies within 120 LSB of the true sine.
- R4: In the pipelined form, `res_valid` equals `ang_valid` delayed by exactly two clock cycles. In the combinational form it equals `ang_valid` in the same cycle.
- R5: For an angle of at least 246 LSB (about 0.03 rad), the sine result is non-negative. For an angle of at most -246 LSB it is negative.
- R6: Angles presented on consecutive cycles each yield one result, in the order they were given, with no gaps.
- R7: In the pipelined form, the result words keep their previous value on every cycle in which `res_valid` is low, whatever angle is applied meanwhile.
- R8: Every valid result word has a magnitude of at most 8300 LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ang_valid | input | 1 | Angle strobe |
| ang_in | input | 16 | Angle in radians, signed, 13 fractional bits |
| res_valid | output | 1 | Result strobe |
| res_cos | output | 16 | Cosine, signed, 13 fractional bits |
| res_sin | output | 16 | Sine, signed, 13 fractional bits |

## Verification
The sign and magnitude properties assume that every angle carried by a strobe lies within the ±1.74 rad convergence range, because nothing in the block folds quadrants. The stimulus table and the directed tests apply only angles from -13926 to +13926 LSB. The timing properties take the result strobe as meaningful only once two clocks have passed since reset. The bench changes the angle freely while the strobe is low, so that the hold behaviour is exercised with inputs that would otherwise alter the result.

// File: rtl/cordic_sincos_pkg.sv
package cordic_sincos_pkg;

    localparam int DW   = 16;
    localparam int FRAC = 13;
    // reciprocal of rotation gain for eight or more rotations, 13 fractional bits
    localparam int START_X = 4975;

    typedef logic signed [DW-1:0] word_t;

    typedef struct packed {
        word_t x;
        word_t y;
        word_t z;
    } vec_t;

    typedef struct packed {
        logic valid;
        vec_t v;
    } beat_t;

    // arctan(2^-k), 13 fractional bits
    function automatic int atan_lsb(input int k);
        case (k)
            0:       atan_lsb = 6434;
            1:       atan_lsb = 3798;
            2:       atan_lsb = 2007;
            3:       atan_lsb = 1019;
            4:       atan_lsb = 511;
            5:       atan_lsb = 256;
            6:       atan_lsb = 128;
            7:       atan_lsb = 64;
            8:       atan_lsb = 32;
            9:       atan_lsb = 16;
            10:      atan_lsb = 8;
            11:      atan_lsb = 4;
            12:      atan_lsb = 2;
            default: atan_lsb = 1;
        endcase
    endfunction

    // x,y after the first three rotations; pat[2] is the first direction (1 = positive)
    function automatic logic [2*DW-1:0] front_pair(input int pat);
        int x;
        int y;
        int nx;
        int ny;
        x = START_X;
        y = 0;
        for (int k = 0; k < 3; k++) begin
            if (((pat >> (2 - k)) & 1) == 1) begin
                nx = x - (y >>> k);
                ny = y + (x >>> k);
            end else begin
                nx = x + (y >>> k);
                ny = y - (x >>> k);
            end
            x = nx;
            y = ny;
        end
        front_pair = {DW'(x), DW'(y)};
    endfunction

    function automatic word_t turn_angle(input word_t z, input logic pos, input int k);
        word_t a;
        a = DW'(atan_lsb(k));
        turn_angle = pos ? (z - a) : (z + a);
    endfunction

endpackage

// File: rtl/cordic_sincos_front.sv
module cordic_sincos_front
    import cordic_sincos_pkg::*;
(
    input  word_t angle,
    output vec_t  vout
);
    localparam int NPAT = 8;

    logic [2*DW-1:0] pair_lut [NPAT];

    generate
        for (genvar p = 0; p < NPAT; p++) begin : g_lut
            assign pair_lut[p] = front_pair(p);
        end
    endgenerate

    logic  dir1, dir2, dir3;
    word_t z1, z2, z3;
    logic [2:0] sel;

    always_comb begin
        dir1 = ~angle[DW-1];
        z1   = turn_angle(angle, dir1, 0);
        dir2 = ~z1[DW-1];
        z2   = turn_angle(z1, dir2, 1);
        dir3 = ~z2[DW-1];
        z3   = turn_angle(z2, dir3, 2);
        sel  = {dir1, dir2, dir3};
        vout.x = pair_lut[sel][2*DW-1:DW];
        vout.y = pair_lut[sel][DW-1:0];
        vout.z = z3;
    end

endmodule

// File: rtl/cordic_sincos_rot.sv
module cordic_sincos_rot
    import cordic_sincos_pkg::*;
#(
    parameter int SHIFT = 3
) (
    input  vec_t vin,
    output vec_t vout
);
    word_t xs, ys, xi, yi;
    logic  pos;

    always_comb begin
        xi  = vin.x;
        yi  = vin.y;
        xs  = xi >>> SHIFT;
        ys  = yi >>> SHIFT;
        pos = ~vin.z[DW-1];
        if (pos) begin
            vout.x = xi - ys;
            vout.y = yi + xs;
        end else begin
            vout.x = xi + ys;
            vout.y = yi - xs;
        end
        vout.z = turn_angle(vin.z, pos, SHIFT);
    end

endmodule

// File: rtl/cordic_sincos_stage_reg.sv
module cordic_sincos_stage_reg
    import cordic_sincos_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t din,
    output beat_t dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            dout.valid <= din.valid;
            if (din.valid) begin
                dout.v <= din.v;
            end
        end
    end

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
    import cordic_sincos_pkg::*;
#(
    parameter int NSTAGE   = 8,
    parameter int PIPELINE = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ang_valid,
    input  logic [DW-1:0] ang_in,
    output logic          res_valid,
    output logic [DW-1:0] res_cos,
    output logic [DW-1:0] res_sin
);
    localparam int FRONT = 3;

    beat_t front_b, mid_b, tail_b, out_b;
    vec_t  chain [FRONT:NSTAGE];

    cordic_sincos_front u_front (
        .angle (word_t'(ang_in)),
        .vout  (front_b.v)
    );
    assign front_b.valid = ang_valid;

    generate
        if (PIPELINE != 0) begin : g_mid_reg
            cordic_sincos_stage_reg u_mid (
                .clk  (clk),
                .rst  (rst),
                .din  (front_b),
                .dout (mid_b)
            );
        end else begin : g_mid_wire
            assign mid_b = front_b;
        end
    endgenerate

    assign chain[FRONT] = mid_b.v;

    generate
        for (genvar i = FRONT; i < NSTAGE; i++) begin : g_rot
            cordic_sincos_rot #(.SHIFT(i)) u_rot (
                .vin  (chain[i]),
                .vout (chain[i+1])
            );
        end
    endgenerate

    assign tail_b.valid = mid_b.valid;
    assign tail_b.v     = chain[NSTAGE];

    generate
        if (PIPELINE != 0) begin : g_out_reg
            cordic_sincos_stage_reg u_out (
                .clk  (clk),
                .rst  (rst),
                .din  (tail_b),
                .dout (out_b)
            );
        end else begin : g_out_wire
            assign out_b = tail_b;
        end
    endgenerate

    assign res_valid = out_b.valid;
    assign res_cos   = out_b.v.x;
    assign res_sin   = out_b.v.y;

endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
    parameter int PIPELINE = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        ang_valid,
    input logic [15:0] ang_in,
    input logic        res_valid,
    input logic [15:0] res_cos,
    input logic [15:0] res_sin
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    generate
        if (PIPELINE != 0) begin : g_pipe
            assert_reset_clears_R1: assert property (@(posedge clk)
                rst |=> (!res_valid && res_cos == 16'd0 && res_sin == 16'd0));

            assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
                (age >= 2'd2) |-> (res_valid == $past(ang_valid, 2)));

            assert_sign_pos_R5: assert property (@(posedge clk) disable iff (rst)
                (age >= 2'd2 && res_valid && $signed($past(ang_in, 2)) >= 246)
                |-> !res_sin[15]);

            assert_sign_neg_R5: assert property (@(posedge clk) disable iff (rst)
                (age >= 2'd2 && res_valid && $signed($past(ang_in, 2)) <= -246)
                |-> res_sin[15]);

            assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
                (age != 2'd0 && !res_valid) |-> ($stable(res_cos) && $stable(res_sin)));

            assert_bounded_R8: assert property (@(posedge clk) disable iff (rst)
                res_valid |-> ($signed(res_cos) <= 8300 && $signed(res_cos) >= -8300 &&
                               $signed(res_sin) <= 8300 && $signed(res_sin) >= -8300));
        end else begin : g_comb
            always_comb begin
                if (!rst) begin
                    assert_same_cycle_R4: assert (res_valid == ang_valid);
                end
            end
        end
    endgenerate

endmodule

bind cordic_sincos cordic_sincos_chk #(.PIPELINE(PIPELINE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ang_valid (ang_valid),
    .ang_in    (ang_in),
    .res_valid (res_valid),
    .res_cos   (res_cos),
    .res_sin   (res_sin)
);

// File: tb/tb_cordic_sincos.sv
module tb_cordic_sincos;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    localparam int TOL  = 120;
    // angle, expected cosine, expected sine (13 fractional bits)
    localparam int VEC [NVEC][3] = '{
        '{0,      8192,  0},
        '{4096,   7189,  3927},
        '{-4096,  7189, -3927},
        '{8192,   4426,  6893},
        '{-8192,  4426, -6893},
        '{12288,  579,   8171},
        '{-12288, 579,  -8171},
        '{2048,   7937,  2027},
        '{13926, -1055,  8124},
        '{-13926,-1055, -8124},
        '{819,    8151,  818},
        '{6434,   5793,  5793}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ang_valid = 1'b0;
    logic [15:0] ang_in = 16'd0;
    logic        res_valid;
    logic [15:0] res_cos, res_sin;

    int checks = 0;
    int errors = 0;
    int rx = 0;
    bit mon_on = 1'b0;
    logic [15:0] last_cos, last_sin;

    always #(CLK_PERIOD/2) clk = ~clk;

    cordic_sincos dut (
        .clk       (clk),
        .rst       (rst),
        .ang_valid (ang_valid),
        .ang_in    (ang_in),
        .res_valid (res_valid),
        .res_cos   (res_cos),
        .res_sin   (res_sin)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // table monitor: results in order, one per input (R6)
    always @(negedge clk) begin
        if (mon_on && res_valid) begin
            if (rx < NVEC) begin
                int c, s;
                c = int'($signed(res_cos));
                s = int'($signed(res_sin));
                check(absd(c, VEC[rx][1]) <= TOL, "R2 cosine", c, VEC[rx][1]);
                check(absd(s, VEC[rx][2]) <= TOL, "R3 sine", s, VEC[rx][2]);
                if (VEC[rx][0] >= 246)  check(s >= 0, "R5 sine sign", s, 0);
                if (VEC[rx][0] <= -246) check(s < 0,  "R5 sine sign", s, -1);
                check(c <= 8300 && c >= -8300 && s <= 8300 && s >= -8300,
                      "R8 bound", (absd(c,0) > absd(s,0)) ? c : s, 8300);
            end
            last_cos = res_cos;
            last_sin = res_sin;
            rx++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        ang_valid = 1'b1;
        ang_in    = 16'd4096;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 valid in reset", int'(res_valid), 0);
        check(res_cos == 16'd0 && res_sin == 16'd0, "R1 data in reset",
              int'(res_cos), 0);
        ang_valid = 1'b0;
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 idle after reset", int'(res_valid), 0);

        // table walked back to back (R2, R3, R5, R6, R8)
        mon_on = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            ang_valid = 1'b1;
            ang_in    = 16'(VEC[i][0]);
            @(negedge clk);
        end
        ang_valid = 1'b0;
        ang_in    = 16'(-8192);
        repeat (4) @(negedge clk);
        mon_on = 1'b0;
        check(rx == NVEC, "R6 result count", rx, NVEC);

        // R7: hold while strobe low with changing angle
        for (int i = 0; i < 4; i++) begin
            ang_in = 16'(1000 * i - 1500);
            @(negedge clk);
            check(res_cos == last_cos && res_sin == last_sin, "R7 hold",
                  int'($signed(res_cos)), int'($signed(last_cos)));
        end

        // R4: single pulse latency of two cycles
        ang_valid = 1'b1;
        ang_in    = 16'd8192;
        @(negedge clk);
        ang_valid = 1'b0;
        ang_in    = 16'd0;
        check(res_valid == 1'b0, "R4 not after one cycle", int'(res_valid), 0);
        @(negedge clk);
        check(res_valid == 1'b1, "R4 after two cycles", int'(res_valid), 1);
        check(absd(int'($signed(res_sin)), 6893) <= TOL, "R3 single pulse sine",
              int'($signed(res_sin)), 6893);
        @(negedge clk);
        check(res_valid == 1'b0, "R4 single beat", int'(res_valid), 0);

        // R1: reset with work in flight
        ang_valid = 1'b1;
        ang_in    = 16'(-4096);
        @(negedge clk);
        ang_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 flush valid", int'(res_valid), 0);
        check(res_sin == 16'd0, "R1 flush data", int'($signed(res_sin)), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(res_valid == 1'b0, "R1 no stale result", int'(res_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule